// File: doc/BRIEF.md
# Reorientable NAND/Flip-Flop Logic Tile

This block is one cell of a fine-grained reconfigurable fabric. It has a single fixed logic core: one two-input NAND gate, one rising-edge D flip-flop and one buffer. The core connects to four sides of the cell (top, bottom, left, right), and each side has one input pin and one output pin. An orientation made of three independent flip bits places the core in any of the eight symmetries of a square. Each flip bit swaps pairs of sides. The flip bits reorder the side inputs before the core, and the matching inverse reordering is applied to the core outputs.

The flip-flop also forms one link of a serial scan chain. With scan mode asserted it captures the serial input rather than the NAND result, and its value always appears on the serial output. This path sets and reads the cell state. It also configures the cell: each flip bit sits in a level-sensitive latch. While a 2-bit load command selects that latch, the latch is transparent to the flip-flop value. When the command returns to idle, the latch freezes.

Top module: `orient_logic_tile`

## Requirements
- R1: Side index encoding in the 4-bit side vectors is bit 0 top, bit 1 bottom, bit 2 left, bit 3 right. The flip state is bit 0 diagonal (swaps top with left and bottom with right), bit 1 horizontal (swaps left with right) and bit 2 vertical (swaps top with bottom). A core side c faces physical side d(h(v(c))) for both its input and its output. Here v, h and d are the vertical, horizontal and diagonal swaps, each applied only when its flip bit is 1.
- R2: The core right output is combinationally the NAND of the core top input and the core left input.
- R3: The core top output is combinationally a copy of the core bottom input.
- R4: The core left output is constant 0.
- R5: With scan_en at 0, the flip-flop captures the core NAND result on each rising clk edge. Its value drives the core bottom output.
- R6: With scan_en at 1, the flip-flop captures scan_in on each rising clk edge.
- R7: scan_out always equals the flip-flop value.
- R8: cfg_cmd 01 makes the vertical flip latch transparent to the flip-flop value, 10 does so for the horizontal flip, and 11 for the diagonal flip. On leaving the command, the latch keeps the last value it saw.
- R9: With cfg_cmd at 00, all three flip bits keep their values whatever the flip-flop does.
- R10: The flip-flop has no reset. Shifting a 0 in through the scan chain clears it, and 0 then appears on scan_out and on the side that faces the core bottom.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for the flip-flop |
| scan_en | input | 1 | 1 selects the serial input as the flip-flop source |
| scan_in | input | 1 | Serial chain input |
| cfg_cmd | input | 2 | Flip-bit load command: 00 idle, 01 vertical, 10 horizontal, 11 diagonal |
| side_in | input | 4 | Side inputs: bit 0 top, 1 bottom, 2 left, 3 right |
| side_out | output | 4 | Side outputs, same bit order |
| scan_out | output | 1 | Serial chain output (flip-flop value) |

## Verification
The bench sets each of the eight orientations through the scan chain and the load commands. For each one it applies all sixteen side-input patterns. This separates every swap combination, because each core side has its own signature: NAND, copy, constant zero or stored bit. A wrong swap or a wrong inverse moves a signature onto another pin. The bench clocks the flip-flop after every pattern, which tests functional capture through the permuted inputs. Separate serial bit sequences test shifting and clearing. A held-command sequence shows that a latch follows the flip-flop while selected and freezes after release. A toggling flip-flop under the idle command shows that the orientation stays fixed.

// File: rtl/orient_tile_pkg.sv
package orient_tile_pkg;

    localparam int NSIDES = 4;
    localparam int SIDE_T = 0;
    localparam int SIDE_B = 1;
    localparam int SIDE_L = 2;
    localparam int SIDE_R = 3;

    typedef logic [NSIDES-1:0] side_vec_t;

    // packed: diag is bit 0, horiz bit 1, vert bit 2
    typedef struct packed {
        logic vert;
        logic horiz;
        logic diag;
    } flip_t;

    localparam int NFLIPS = $bits(flip_t);
    localparam int CMD_W  = 2;

    typedef enum logic [CMD_W-1:0] {
        CMD_HOLD  = 2'b00,
        CMD_VERT  = 2'b01,
        CMD_HORIZ = 2'b10,
        CMD_DIAG  = 2'b11
    } cfg_cmd_e;

    function automatic side_vec_t swap_sides(side_vec_t v, int a, int b);
        side_vec_t r;
        r    = v;
        r[a] = v[b];
        r[b] = v[a];
        return r;
    endfunction

    function automatic side_vec_t flip_diag(side_vec_t v, logic en);
        side_vec_t r;
        r = v;
        if (en) begin
            r = swap_sides(r, SIDE_T, SIDE_L);
            r = swap_sides(r, SIDE_B, SIDE_R);
        end
        return r;
    endfunction

    function automatic side_vec_t flip_horiz(side_vec_t v, logic en);
        return en ? swap_sides(v, SIDE_L, SIDE_R) : v;
    endfunction

    function automatic side_vec_t flip_vert(side_vec_t v, logic en);
        return en ? swap_sides(v, SIDE_T, SIDE_B) : v;
    endfunction

    // load command for flip bit k: diag(0)->11, horiz(1)->10, vert(2)->01
    function automatic logic [CMD_W-1:0] load_code(int k);
        return CMD_W'(NFLIPS - k);
    endfunction

endpackage

// File: rtl/orient_side_perm.sv
module orient_side_perm
    import orient_tile_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  flip_t     flips,
    input  side_vec_t vec_in,
    output side_vec_t vec_out
);

    side_vec_t stage1;
    side_vec_t stage2;

    generate
        if (INVERSE) begin : g_outward
            // undo in reverse order: vertical, horizontal, diagonal
            assign stage1  = flip_vert(vec_in, flips.vert);
            assign stage2  = flip_horiz(stage1, flips.horiz);
            assign vec_out = flip_diag(stage2, flips.diag);
        end else begin : g_inward
            assign stage1  = flip_diag(vec_in, flips.diag);
            assign stage2  = flip_horiz(stage1, flips.horiz);
            assign vec_out = flip_vert(stage2, flips.vert);
        end
    endgenerate

endmodule

// File: rtl/orient_flip_latches.sv
module orient_flip_latches
    import orient_tile_pkg::*;
(
    input  logic [CMD_W-1:0] cmd,
    input  logic             d,
    output flip_t            flips
);

    logic [NFLIPS-1:0] bits_q;

    generate
        for (genvar k = 0; k < NFLIPS; k++) begin : g_bit
            localparam logic [CMD_W-1:0] CODE = load_code(k);
            logic hold_q;
            always_latch begin
                if (cmd == CODE) hold_q = d;
            end
            assign bits_q[k] = hold_q;
        end
    endgenerate

    assign flips = flip_t'(bits_q);

endmodule

// File: rtl/orient_tile_core.sv
module orient_tile_core
    import orient_tile_pkg::*;
(
    input  logic      clk,
    input  logic      scan_en,
    input  logic      scan_in,
    input  side_vec_t core_in,
    output side_vec_t core_out,
    output logic      state_q
);

    logic nand_w;
    logic d_next;

    assign nand_w = ~(core_in[SIDE_T] & core_in[SIDE_L]);
    assign d_next = scan_en ? scan_in : nand_w;

    always_ff @(posedge clk) begin
        state_q <= d_next;
    end

    always_comb begin
        core_out         = '0;
        core_out[SIDE_R] = nand_w;
        core_out[SIDE_B] = state_q;
        core_out[SIDE_T] = core_in[SIDE_B];
        core_out[SIDE_L] = 1'b0;
    end

endmodule

// File: rtl/orient_logic_tile.sv
module orient_logic_tile
    import orient_tile_pkg::*;
(
    input  logic              clk,
    input  logic              scan_en,
    input  logic              scan_in,
    input  logic [CMD_W-1:0]  cfg_cmd,
    input  logic [NSIDES-1:0] side_in,
    output logic [NSIDES-1:0] side_out,
    output logic              scan_out
);

    flip_t     flips;
    side_vec_t core_in;
    side_vec_t core_out;
    logic      state_q;

    orient_flip_latches u_latches (
        .cmd   (cfg_cmd),
        .d     (state_q),
        .flips (flips)
    );

    orient_side_perm #(.INVERSE(1'b0)) u_perm_in (
        .flips   (flips),
        .vec_in  (side_in),
        .vec_out (core_in)
    );

    orient_tile_core u_core (
        .clk      (clk),
        .scan_en  (scan_en),
        .scan_in  (scan_in),
        .core_in  (core_in),
        .core_out (core_out),
        .state_q  (state_q)
    );

    orient_side_perm #(.INVERSE(1'b1)) u_perm_out (
        .flips   (flips),
        .vec_in  (core_out),
        .vec_out (side_out)
    );

    assign scan_out = state_q;

endmodule

// File: rtl/orient_logic_tile_chk.sv
module orient_logic_tile_chk
    import orient_tile_pkg::*;
(
    input logic              clk,
    input logic              scan_en,
    input logic              scan_in,
    input logic [CMD_W-1:0]  cfg_cmd,
    input logic              scan_out,
    input logic [NFLIPS-1:0] flip_bits,
    input logic [NSIDES-1:0] core_in
);

    logic started = 1'b0;
    always_ff @(posedge clk) started <= 1'b1;

    a_r6_scan_capture: assert property (@(posedge clk) disable iff (!started)
        scan_en |=> scan_out == $past(scan_in));

    a_r5_func_capture: assert property (@(posedge clk) disable iff (!started)
        !scan_en |=> scan_out == $past(~(core_in[SIDE_T] & core_in[SIDE_L])));

    a_r8_vert_follow: assert property (@(posedge clk) disable iff (!started)
        (cfg_cmd == CMD_VERT) |-> flip_bits[2] == scan_out);

    a_r8_horiz_follow: assert property (@(posedge clk) disable iff (!started)
        (cfg_cmd == CMD_HORIZ) |-> flip_bits[1] == scan_out);

    a_r8_diag_follow: assert property (@(posedge clk) disable iff (!started)
        (cfg_cmd == CMD_DIAG) |-> flip_bits[0] == scan_out);

    a_r9_hold: assert property (@(posedge clk) disable iff (!started)
        (cfg_cmd == CMD_HOLD && $past(cfg_cmd) == CMD_HOLD) |-> $stable(flip_bits));

endmodule

bind orient_logic_tile orient_logic_tile_chk u_chk (
    .clk       (clk),
    .scan_en   (scan_en),
    .scan_in   (scan_in),
    .cfg_cmd   (cfg_cmd),
    .scan_out  (scan_out),
    .flip_bits (flips),
    .core_in   (core_in)
);

// File: tb/orient_logic_tile_test.sv
module orient_logic_tile_test;

    localparam int T = 0, B = 1, L = 2, R = 3;

    logic       clk = 1'b0;
    logic       scan_en = 1'b0;
    logic       scan_in = 1'b0;
    logic [1:0] cfg_cmd = 2'b00;
    logic [3:0] side_in = 4'b0000;
    logic [3:0] side_out;
    logic       scan_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    orient_logic_tile uut (
        .clk      (clk),
        .scan_en  (scan_en),
        .scan_in  (scan_in),
        .cfg_cmd  (cfg_cmd),
        .side_in  (side_in),
        .side_out (side_out),
        .scan_out (scan_out)
    );

    always #5 clk = ~clk;

    // physical side facing core side c under orientation o (R1)
    function automatic int phys_of(logic [2:0] o, int c);
        int p = c;
        if (o[2]) p = (p == T) ? B : (p == B) ? T : p;
        if (o[1]) p = (p == L) ? R : (p == R) ? L : p;
        if (o[0]) p = (p == T) ? L : (p == L) ? T : (p == B) ? R : (p == R) ? B : p;
        return p;
    endfunction

    function automatic logic [3:0] expect_out(logic [2:0] o, logic [3:0] v, logic q);
        logic [3:0] ci, co, res;
        for (int c = 0; c < 4; c++) ci[c] = v[phys_of(o, c)];
        co[T] = ci[B];
        co[B] = q;
        co[L] = 1'b0;
        co[R] = ~(ci[T] & ci[L]);
        res = '0;
        for (int c = 0; c < 4; c++) res[phys_of(o, c)] = co[c];
        return res;
    endfunction

    function automatic logic nand_of(logic [2:0] o, logic [3:0] v);
        return ~(v[phys_of(o, T)] & v[phys_of(o, L)]);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock edge, then settle 2 ns past it
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic scan_bit(logic b);
        scan_en = 1'b1;
        scan_in = b;
        tick();
    endtask

    task automatic load_flip(logic b, logic [1:0] code);
        scan_bit(b);
        cfg_cmd = code;
        tick();
        cfg_cmd = 2'b00;
    endtask

    task automatic set_orient(logic [2:0] o);
        load_flip(o[0], 2'b11);
        load_flip(o[1], 2'b10);
        load_flip(o[2], 2'b01);
    endtask

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
        if (!done) begin
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic q_exp;
        logic [3:0] exp_v;
        logic [7:0] lfsr;
        #2;

        // R10: clear by shifting zero, then the cleared state
        set_orient(3'b000);
        scan_bit(1'b0);
        check(scan_out == 1'b0, "R10 cleared scan_out", scan_out, 0);
        side_in = 4'b0000;
        #1;
        check(side_out[B] == 1'b0, "R10 cleared bottom side", side_out, expect_out(3'b000, 4'b0000, 1'b0));

        // R1 R2 R3 R4 R5: all orientations times all side patterns
        for (int o = 0; o < 8; o++) begin
            set_orient(3'(o));
            q_exp = 1'(o >> 2);
            scan_en = 1'b0;
            for (int v = 0; v < 16; v++) begin
                side_in = 4'(v);
                #1;
                exp_v = expect_out(3'(o), 4'(v), q_exp);
                check(side_out == exp_v, $sformatf("R1 R2 R3 R4 o=%0d v=%0d", o, v), side_out, exp_v);
                tick();
                q_exp = nand_of(3'(o), 4'(v));
                check(scan_out == q_exp, $sformatf("R5 capture o=%0d v=%0d", o, v), scan_out, q_exp);
            end
        end

        // R6 R7: shift a pseudo-random sequence
        set_orient(3'b011);
        side_in = 4'b1010;
        lfsr = 8'hA5;
        for (int i = 0; i < 24; i++) begin
            scan_bit(lfsr[0]);
            check(scan_out == lfsr[0], "R6 scan capture", scan_out, lfsr[0]);
            exp_v = expect_out(3'b011, 4'b1010, lfsr[0]);
            check(side_out == exp_v, "R7 stored bit on sides", side_out, exp_v);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        end

        // R8: vertical latch follows while selected, freezes on release
        set_orient(3'b000);
        side_in = 4'b0001;
        scan_bit(1'b1);
        cfg_cmd = 2'b01;
        tick();
        #1;
        exp_v = expect_out(3'b100, 4'b0001, 1'b1);
        check(side_out == exp_v, "R8 vertical follows 1", side_out, exp_v);
        scan_bit(1'b0);
        #1;
        exp_v = expect_out(3'b000, 4'b0001, 1'b0);
        check(side_out == exp_v, "R8 vertical follows 0", side_out, exp_v);
        scan_bit(1'b1);
        cfg_cmd = 2'b00;
        tick();
        scan_bit(1'b0);
        #1;
        exp_v = expect_out(3'b100, 4'b0001, 1'b0);
        check(side_out == exp_v, "R8 vertical frozen", side_out, exp_v);

        // R8: horizontal and diagonal latches pick their own bit
        set_orient(3'b000);
        load_flip(1'b1, 2'b10);
        side_in = 4'b0100;
        #1;
        exp_v = expect_out(3'b010, 4'b0100, 1'b1);
        check(side_out == exp_v, "R8 horizontal only", side_out, exp_v);
        set_orient(3'b000);
        load_flip(1'b1, 2'b11);
        side_in = 4'b0110;
        #1;
        exp_v = expect_out(3'b001, 4'b0110, 1'b1);
        check(side_out == exp_v, "R8 diagonal only", side_out, exp_v);

        // R9: idle command keeps orientation while the flip-flop toggles
        set_orient(3'b101);
        side_in = 4'b1001;
        for (int i = 0; i < 6; i++) begin
            scan_bit(1'(i & 1));
            #1;
            exp_v = expect_out(3'b101, 4'b1001, 1'(i & 1));
            check(side_out == exp_v, "R9 hold", side_out, exp_v);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule